// File: doc/BRIEF.md
# Split-Screen Display Address Generator

This block produces the frame-memory word address fetched on each display memory cycle of a raster-scanned screen. The picture is built from three horizontal background bands stacked from the top (upper, then base, then lower) and one rectangular window. Each of the four screens has its own start address, memory stride (row pitch in words), enable and blank control. The block takes the horizontal position in memory cycles and the vertical position in rasters from an external timing generator. From them it works out which screen owns the current cycle, that screen's line address and its column offset. The result is one registered address stream with a screen identifier and a display-enable flag.

The window normally wins over any band it overlaps. In superimpose mode it has equal standing: the primary outputs carry the background fetch, and a second set of overlay outputs carries the window fetch for the same cycle. The address step taken per display cycle is chosen by a 3-bit code, so the block can feed displays with more bits per pixel.

Top module: `sdag_top`

## Requirements
- R1: All outputs are registered, one clock after the position and control inputs they depend on. While rst_n is low every output is zero.
- R2: Rows 0 to band_h[0]-1 belong to the upper band (id 0). The next band_h[1] rows belong to the base band (id 1), and the next band_h[2] rows to the lower band (id 2). A band of height zero is skipped. Rows below the three bands have no background.
- R3: Backgrounds are shown only for hpos from 0 to disp_w inclusive, a displayed width of disp_w+1 memory cycles. Beyond that there is no background.
- R4: The window (id 3) covers hpos from win_hs to win_hs+win_hw inclusive and vpos from win_vs to win_vs+win_vw-1. When superimpose is 0 and the window is enabled, it takes the primary outputs wherever it covers.
- R5: When superimpose is 1, the primary outputs carry the background. ovl_act/ovl_addr/ovl_den carry the enabled window wherever it covers. Otherwise ovl_act, ovl_den and ovl_addr are 0.
- R6: A screen's address is start_addr + mem_width × row + column offset, modulo 2^20. Here row counts rasters from the screen's first row.
- R7: The column counts memory cycles from the screen's left edge (0 for bands, win_hs for the window). The offset for step_code 000/001/010/011/100 is column×1/2/4/8/16. For 101 it is 0, and for 11x it is column/2, rounded down.
- R8: A screen whose scr_en bit (bit index = id) is 0 produces nothing. Where no enabled screen applies, act, den and address are 0 and pri_id is 0. A disabled window lets the background show through.
- R9: A screen whose scr_blank bit is 1 still produces its address and act = 1, but its display-enable is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hpos | input | HW | Horizontal position in memory cycles |
| vpos | input | VW | Vertical position in rasters |
| disp_w | input | HW | Background displayed width minus one |
| band_h | input | 3×VW | Heights of upper, base, lower bands (index 0..2) |
| win_hs | input | HW | Window horizontal start |
| win_hw | input | HW | Window width minus one, in memory cycles |
| win_vs | input | VW | Window first raster |
| win_vw | input | VW | Window height in rasters |
| start_addr | input | 4×AW | Per-screen start address, index = screen id |
| mem_width | input | 4×MWW | Per-screen memory stride in words |
| scr_en | input | 4 | Per-screen enable |
| scr_blank | input | 4 | Per-screen blank |
| step_code | input | 3 | Column address step select |
| superimpose | input | 1 | Window shares priority with background |
| pri_addr | output | AW | Primary fetch address |
| pri_id | output | 2 | Primary screen id |
| pri_act | output | 1 | Primary address valid |
| pri_den | output | 1 | Primary display enable |
| ovl_addr | output | AW | Overlay (window) fetch address |
| ovl_act | output | 1 | Overlay address valid |
| ovl_den | output | 1 | Overlay display enable |

## Verification
The hardest state to reach is a cycle where the window, a band boundary and the right edge of the displayed area meet. The address must also cross the top of the 2^20-word space, with the window disabled or blanked. A stride-times-row carry out of 20 bits only shows up for large strides and start addresses near the top. The stimulus scans complete small frames under several configurations. Band heights are placed so that the window straddles the upper/base boundary. The configurations include narrow display widths, every step code and start addresses just below the wrap point. A behavioural model in the bench is compared against the outputs on every clock.

// File: rtl/sdag_pkg.sv
package sdag_pkg;
   typedef logic [1:0] scr_id_t;

   localparam scr_id_t SCR_UPPER  = 2'd0;
   localparam scr_id_t SCR_BASE   = 2'd1;
   localparam scr_id_t SCR_LOWER  = 2'd2;
   localparam scr_id_t SCR_WINDOW = 2'd3;

   typedef enum logic [2:0] {
      STEP_X1   = 3'd0,
      STEP_X2   = 3'd1,
      STEP_X4   = 3'd2,
      STEP_X8   = 3'd3,
      STEP_X16  = 3'd4,
      STEP_HOLD = 3'd5,
      STEP_HLFA = 3'd6,
      STEP_HLFB = 3'd7
   } step_e;
endpackage

// File: rtl/sdag_band_sel.sv
module sdag_band_sel
   import sdag_pkg::*;
#(
   parameter int VW = 10
) (
   input  logic [VW-1:0]      vpos,
   input  logic [2:0][VW-1:0] band_h,
   output logic               hit,
   output scr_id_t            id,
   output logic [VW-1:0]      row
);
   localparam int BW = VW + 2;

   logic [BW-1:0] bnd_hi [3];
   logic [BW-1:0] bnd_lo [3];
   logic [BW-1:0] vpos_w;

   assign vpos_w = BW'(vpos);

   // cumulative band boundaries, upper band first
   for (genvar g = 0; g < 3; g++) begin : g_bnd
      if (g == 0) begin : g_first
         assign bnd_lo[g] = '0;
         assign bnd_hi[g] = BW'(band_h[g]);
      end else begin : g_next
         assign bnd_lo[g] = bnd_hi[g-1];
         assign bnd_hi[g] = bnd_hi[g-1] + BW'(band_h[g]);
      end
   end

   // scan from the bottom so the topmost matching band wins
   always_comb begin
      hit = 1'b0;
      id  = SCR_UPPER;
      row = '0;
      for (int i = 2; i >= 0; i--) begin
         if (vpos_w < bnd_hi[i]) begin
            hit = 1'b1;
            id  = 2'(i);
            row = VW'(vpos_w - bnd_lo[i]);
         end
      end
   end
endmodule

// File: rtl/sdag_win_hit.sv
module sdag_win_hit #(
   parameter int HW = 8,
   parameter int VW = 10
) (
   input  logic [HW-1:0] hpos,
   input  logic [VW-1:0] vpos,
   input  logic [HW-1:0] win_hs,
   input  logic [HW-1:0] win_hw,
   input  logic [VW-1:0] win_vs,
   input  logic [VW-1:0] win_vw,
   output logic          hit,
   output logic [VW-1:0] row,
   output logic [HW-1:0] col
);
   logic [HW:0] h_last;
   logic [VW:0] v_end;
   logic        h_in;
   logic        v_in;

   assign h_last = {1'b0, win_hs} + {1'b0, win_hw};
   assign v_end  = {1'b0, win_vs} + {1'b0, win_vw};
   assign h_in   = (hpos >= win_hs) && ({1'b0, hpos} <= h_last);
   assign v_in   = (vpos >= win_vs) && ({1'b0, vpos} < v_end);
   assign hit    = h_in && v_in;
   assign row    = vpos - win_vs;
   assign col    = hpos - win_hs;
endmodule

// File: rtl/sdag_addr_gen.sv
module sdag_addr_gen
   import sdag_pkg::*;
#(
   parameter int AW  = 20,
   parameter int HW  = 8,
   parameter int VW  = 10,
   parameter int MWW = 12
) (
   input  logic [AW-1:0]  base,
   input  logic [MWW-1:0] stride,
   input  logic [VW-1:0]  row,
   input  logic [HW-1:0]  col,
   input  logic [2:0]     step_code,
   output logic [AW-1:0]  addr
);
   localparam int LW = AW + MWW + VW + HW + 5;

   logic [LW-1:0] line_w;
   logic [LW-1:0] off_w;
   logic [LW-1:0] sum_w;

   assign line_w = LW'(base) + LW'(stride) * LW'(row);

   always_comb begin
      unique case (step_e'(step_code))
         STEP_X1, STEP_X2, STEP_X4, STEP_X8, STEP_X16:
            off_w = LW'(col) << step_code;
         STEP_HOLD:
            off_w = '0;
         default:
            off_w = LW'(col >> 1);
      endcase
   end

   assign sum_w = line_w + off_w;
   assign addr  = sum_w[AW-1:0];
endmodule

// File: rtl/sdag_top.sv
module sdag_top
   import sdag_pkg::*;
#(
   parameter int AW  = 20,
   parameter int HW  = 8,
   parameter int VW  = 10,
   parameter int MWW = 12
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [HW-1:0]        hpos,
   input  logic [VW-1:0]        vpos,
   input  logic [HW-1:0]        disp_w,
   input  logic [2:0][VW-1:0]   band_h,
   input  logic [HW-1:0]        win_hs,
   input  logic [HW-1:0]        win_hw,
   input  logic [VW-1:0]        win_vs,
   input  logic [VW-1:0]        win_vw,
   input  logic [3:0][AW-1:0]   start_addr,
   input  logic [3:0][MWW-1:0]  mem_width,
   input  logic [3:0]           scr_en,
   input  logic [3:0]           scr_blank,
   input  logic [2:0]           step_code,
   input  logic                 superimpose,
   output logic [AW-1:0]        pri_addr,
   output logic [1:0]           pri_id,
   output logic                 pri_act,
   output logic                 pri_den,
   output logic [AW-1:0]        ovl_addr,
   output logic                 ovl_act,
   output logic                 ovl_den
);
   localparam int NLANE = 2;
   localparam int LN_BG = 0;
   localparam int LN_WN = 1;

   if (AW < HW + 5) begin : g_bad_aw
      $error("sdag_top: AW must hold a column shifted by four");
   end
   if (MWW < 1 || VW < 2 || HW < 2) begin : g_bad_w
      $error("sdag_top: width parameters too small");
   end

   // background band lookup
   logic          bg_hit;
   scr_id_t       bg_id;
   logic [VW-1:0] bg_row;

   sdag_band_sel #(.VW(VW)) u_band (
      .vpos   (vpos),
      .band_h (band_h),
      .hit    (bg_hit),
      .id     (bg_id),
      .row    (bg_row)
   );

   // window lookup
   logic          wn_hit;
   logic [VW-1:0] wn_row;
   logic [HW-1:0] wn_col;

   sdag_win_hit #(.HW(HW), .VW(VW)) u_win (
      .hpos   (hpos),
      .vpos   (vpos),
      .win_hs (win_hs),
      .win_hw (win_hw),
      .win_vs (win_vs),
      .win_vw (win_vw),
      .hit    (wn_hit),
      .row    (wn_row),
      .col    (wn_col)
   );

   // address lanes: one for the background, one for the window
   logic [NLANE-1:0][AW-1:0]  ln_base;
   logic [NLANE-1:0][MWW-1:0] ln_stride;
   logic [NLANE-1:0][VW-1:0]  ln_row;
   logic [NLANE-1:0][HW-1:0]  ln_col;
   logic [NLANE-1:0][AW-1:0]  ln_addr;

   assign ln_base[LN_BG]   = start_addr[bg_id];
   assign ln_stride[LN_BG] = mem_width[bg_id];
   assign ln_row[LN_BG]    = bg_row;
   assign ln_col[LN_BG]    = hpos;
   assign ln_base[LN_WN]   = start_addr[SCR_WINDOW];
   assign ln_stride[LN_WN] = mem_width[SCR_WINDOW];
   assign ln_row[LN_WN]    = wn_row;
   assign ln_col[LN_WN]    = wn_col;

   for (genvar g = 0; g < NLANE; g++) begin : g_lane
      sdag_addr_gen #(.AW(AW), .HW(HW), .VW(VW), .MWW(MWW)) u_gen (
         .base      (ln_base[g]),
         .stride    (ln_stride[g]),
         .row       (ln_row[g]),
         .col       (ln_col[g]),
         .step_code (step_code),
         .addr      (ln_addr[g])
      );
   end

   // ownership of the cycle
   logic bg_live;
   logic wn_live;
   assign bg_live = bg_hit && (hpos <= disp_w) && scr_en[bg_id];
   assign wn_live = wn_hit && scr_en[SCR_WINDOW];

   logic [AW-1:0] pri_addr_d;
   scr_id_t       pri_id_d;
   logic          pri_act_d;
   logic          pri_den_d;
   logic [AW-1:0] ovl_addr_d;
   logic          ovl_act_d;
   logic          ovl_den_d;

   always_comb begin
      pri_addr_d = '0;
      pri_id_d   = SCR_UPPER;
      pri_act_d  = 1'b0;
      pri_den_d  = 1'b0;
      ovl_addr_d = '0;
      ovl_act_d  = 1'b0;
      ovl_den_d  = 1'b0;
      if (wn_live && !superimpose) begin
         pri_addr_d = ln_addr[LN_WN];
         pri_id_d   = SCR_WINDOW;
         pri_act_d  = 1'b1;
         pri_den_d  = !scr_blank[SCR_WINDOW];
      end else if (bg_live) begin
         pri_addr_d = ln_addr[LN_BG];
         pri_id_d   = bg_id;
         pri_act_d  = 1'b1;
         pri_den_d  = !scr_blank[bg_id];
      end
      if (wn_live && superimpose) begin
         ovl_addr_d = ln_addr[LN_WN];
         ovl_act_d  = 1'b1;
         ovl_den_d  = !scr_blank[SCR_WINDOW];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pri_addr <= '0;
         pri_id   <= SCR_UPPER;
         pri_act  <= 1'b0;
         pri_den  <= 1'b0;
         ovl_addr <= '0;
         ovl_act  <= 1'b0;
         ovl_den  <= 1'b0;
      end else begin
         pri_addr <= pri_addr_d;
         pri_id   <= pri_id_d;
         pri_act  <= pri_act_d;
         pri_den  <= pri_den_d;
         ovl_addr <= ovl_addr_d;
         ovl_act  <= ovl_act_d;
         ovl_den  <= ovl_den_d;
      end
   end

   // R9
   pri_den_act_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pri_den |-> pri_act);

   // R9
   pri_blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pri_den |-> ((($past(scr_blank) >> pri_id) & 4'd1) == 4'd0));

   // R8
   pri_enabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pri_act |-> ((($past(scr_en) >> pri_id) & 4'd1) != 4'd0));

   // R8
   idle_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !pri_act |-> (pri_addr == '0 && !pri_den));

   // R5
   ovl_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ovl_act |-> $past(superimpose));

   // R4
   win_primary_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pri_act && pri_id == SCR_WINDOW) |-> !$past(superimpose));

   // R3
   bg_extent_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pri_act && pri_id != SCR_WINDOW) |-> ($past(hpos) <= $past(disp_w)));
endmodule

// File: tb/tb_sdag_top.sv
module tb_sdag_top;
   localparam int AW  = 20;
   localparam int HW  = 8;
   localparam int VW  = 10;
   localparam int MWW = 12;
   localparam int CLK_PERIOD = 10;
   localparam int HMAX = 15;
   localparam int VMAX = 12;

   logic                 clk = 1'b0;
   logic                 rst_n = 1'b0;
   logic [HW-1:0]        hpos = '0;
   logic [VW-1:0]        vpos = '0;
   logic [HW-1:0]        disp_w = '0;
   logic [2:0][VW-1:0]   band_h = '0;
   logic [HW-1:0]        win_hs = '0;
   logic [HW-1:0]        win_hw = '0;
   logic [VW-1:0]        win_vs = '0;
   logic [VW-1:0]        win_vw = '0;
   logic [3:0][AW-1:0]   start_addr = '0;
   logic [3:0][MWW-1:0]  mem_width = '0;
   logic [3:0]           scr_en = '0;
   logic [3:0]           scr_blank = '0;
   logic [2:0]           step_code = '0;
   logic                 superimpose = 1'b0;
   logic [AW-1:0]        pri_addr;
   logic [1:0]           pri_id;
   logic                 pri_act;
   logic                 pri_den;
   logic [AW-1:0]        ovl_addr;
   logic                 ovl_act;
   logic                 ovl_den;

   sdag_top #(.AW(AW), .HW(HW), .VW(VW), .MWW(MWW)) dut (
      .clk, .rst_n, .hpos, .vpos, .disp_w, .band_h, .win_hs, .win_hw,
      .win_vs, .win_vw, .start_addr, .mem_width, .scr_en, .scr_blank,
      .step_code, .superimpose, .pri_addr, .pri_id, .pri_act, .pri_den,
      .ovl_addr, .ovl_act, .ovl_den
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   int    n_checks = 0;
   int    n_errors = 0;
   bit    done = 1'b0;
   string cur_req = "R1";

   bit      exp_ok = 1'b0;
   longint  e_paddr, e_oaddr;
   int      e_pid;
   bit      e_pact, e_pden, e_oact, e_oden;

   function automatic longint col_off(int c, int code);
      if (code <= 4) return longint'(c) * (longint'(1) << code);
      if (code == 5) return 0;
      return longint'(c / 2);
   endfunction

   function automatic longint scr_addr(int s, int r, int c);
      longint a;
      a = longint'(start_addr[s]) + longint'(mem_width[s]) * r + col_off(c, int'(step_code));
      return a & ((longint'(1) << AW) - 1);
   endfunction

   task automatic model(int h, int v);
      int  b0, b1, b2, bid, brow;
      bit  bhit, whit;
      b0 = int'(band_h[0]); b1 = b0 + int'(band_h[1]); b2 = b1 + int'(band_h[2]);
      bhit = 1'b1; bid = 0; brow = 0;
      if (v < b0) begin bid = 0; brow = v; end
      else if (v < b1) begin bid = 1; brow = v - b0; end
      else if (v < b2) begin bid = 2; brow = v - b1; end
      else bhit = 1'b0;
      bhit = bhit && (h <= int'(disp_w)) && scr_en[bid];
      whit = (h >= int'(win_hs)) && (h <= int'(win_hs) + int'(win_hw)) &&
             (v >= int'(win_vs)) && (v < int'(win_vs) + int'(win_vw)) && scr_en[3];
      e_paddr = 0; e_pid = 0; e_pact = 0; e_pden = 0;
      e_oaddr = 0; e_oact = 0; e_oden = 0;
      if (whit && !superimpose) begin
         e_paddr = scr_addr(3, v - int'(win_vs), h - int'(win_hs));
         e_pid = 3; e_pact = 1; e_pden = !scr_blank[3];
      end else if (bhit) begin
         e_paddr = scr_addr(bid, brow, h);
         e_pid = bid; e_pact = 1; e_pden = !scr_blank[bid];
      end
      if (whit && superimpose) begin
         e_oaddr = scr_addr(3, v - int'(win_vs), h - int'(win_hs));
         e_oact = 1; e_oden = !scr_blank[3];
      end
   endtask

   task automatic compare();
      n_checks++;
      if (pri_addr !== AW'(e_paddr) || pri_id !== 2'(e_pid) || pri_act !== e_pact ||
          pri_den !== e_pden || ovl_addr !== AW'(e_oaddr) || ovl_act !== e_oact ||
          ovl_den !== e_oden) begin
         n_errors++;
         $display("FAIL %s h=%0d v=%0d actual pa=%h id=%0d act=%0b den=%0b oa=%h oact=%0b oden=%0b expected pa=%h id=%0d act=%0b den=%0b oa=%h oact=%0b oden=%0b",
                  cur_req, hpos, vpos, pri_addr, pri_id, pri_act, pri_den, ovl_addr, ovl_act, ovl_den,
                  AW'(e_paddr), e_pid, e_pact, e_pden, AW'(e_oaddr), e_oact, e_oden);
      end
   endtask

   // one display cycle: check the result of the previous inputs, then drive new ones
   task automatic step(int h, int v);
      @(negedge clk);
      if (exp_ok) compare();
      hpos = HW'(h);
      vpos = VW'(v);
      model(h, v);
      exp_ok = 1'b1;
   endtask

   task automatic scan_frame();
      for (int v = 0; v <= VMAX; v++)
         for (int h = 0; h <= HMAX; h++)
            step(h, v);
   endtask

   task automatic base_cfg();
      disp_w = 8'd11;
      band_h[0] = 10'd3; band_h[1] = 10'd4; band_h[2] = 10'd2;
      win_hs = 8'd4; win_hw = 8'd3; win_vs = 10'd2; win_vw = 10'd4;
      for (int s = 0; s < 4; s++) begin
         start_addr[s] = AW'($urandom_range(0, 20'h7FFFF));
         mem_width[s]  = MWW'($urandom_range(16, 200));
      end
      scr_en = 4'b1111; scr_blank = 4'b0000;
      step_code = 3'd0; superimpose = 1'b0;
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      if (!done) begin
         n_errors++;
         $display("FAIL watchdog expired");
         $display("Result: errors=%0d of %0d checks", n_errors, n_checks + 1);
         $finish;
      end
   end

   initial begin
      base_cfg();
      hpos = 8'd5; vpos = 10'd3;
      repeat (3) @(negedge clk);
      // R1: reset state
      cur_req = "R1";
      e_paddr = 0; e_pid = 0; e_pact = 0; e_pden = 0; e_oaddr = 0; e_oact = 0; e_oden = 0;
      compare();
      rst_n = 1'b1;

      // R2: band stacking, window disabled so only bands appear (zero-height base later)
      cur_req = "R2";
      scr_en = 4'b0111;
      scan_frame();
      band_h[1] = 10'd0;
      scan_frame();

      // R4: window priority over the upper/base boundary
      cur_req = "R4";
      base_cfg();
      scan_frame();

      // R5: superimpose, both fetches
      cur_req = "R5";
      superimpose = 1'b1;
      scan_frame();

      // R7: every step code
      cur_req = "R7";
      superimpose = 1'b0;
      for (int c = 1; c < 8; c++) begin
         step_code = 3'(c);
         scan_frame();
      end

      // R6: wrap modulo 2^20 with large strides
      cur_req = "R6";
      base_cfg();
      for (int s = 0; s < 4; s++) begin
         start_addr[s] = AW'(20'hFFFF0 + s);
         mem_width[s]  = MWW'(12'hFFF - s);
      end
      step_code = 3'd4;
      scan_frame();

      // R8: disabled screens, window disabled lets background through
      cur_req = "R8";
      base_cfg();
      scr_en = 4'b0010;
      scan_frame();

      // R9: blanked screens keep addressing
      cur_req = "R9";
      base_cfg();
      scr_blank = 4'b1101;
      scan_frame();
      superimpose = 1'b1;
      scan_frame();

      // R3: narrow displayed width, window beyond it
      cur_req = "R3";
      base_cfg();
      disp_w = 8'd5;
      win_hs = 8'd9; win_hw = 8'd0;
      scan_frame();

      @(negedge clk);
      compare();
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   end
endmodule